// File: doc/BRIEF.md
# Self-Seeding Maximum-Length MASH Modulator

This block is a three-stage cascaded accumulator delta-sigma modulator that drives the modulus control of a fractional-N divider. It runs at the reference rate. Each cycle it turns an unsigned fractional word into a small signed offset, and that offset is added to the integer divide ratio. Over time the offsets average to the fractional value, and the quantization error is pushed towards high frequencies.

Short cycles are a problem in a plain MASH, where inputs such as zero or powers of two give very short output periods. Here, each stage instead adds its own carry from the previous cycle back into its sum. This makes every stage a modulo-(2^N−1) accumulator, so the period stays long for every input. Stage 1 is seeded with one at reset, so that a zero input still excites the later stages. The three carries are combined by a third-order error-cancelling network into an output between −3 and +4.

Top module: `mash_dsm`

## Requirements
- R1: Reset (active-low, asynchronous) sets the stage-1 accumulator to 1 and clears every other accumulator, every carry register and every cancellation delay register. The output is 0 while enable is low after reset. With enable high, the first output is 0.
- R2: On each enabled clock, every stage computes the (N+1)-bit sum of its accumulator, its input and its own carry register. The low N bits become the new accumulator and bit N becomes the new carry register. The stored carry is therefore the feedback used one cycle later.
- R3: Stage 1 adds the fractional input. Stage 2 adds the stage-1 accumulator register, and stage 3 adds the stage-2 accumulator register.
- R4: With enable high, the output is c1 delayed two cycles, plus (c2 delayed one cycle minus c2 delayed two cycles), plus (c3 − 2·c3 delayed one cycle + c3 delayed two cycles). Here ck is the stage-k carry register, and the delay registers advance only on enabled clocks. The output is 4-bit two's complement.
- R5: The output always lies in −3 to +4.
- R6: While enable is low, no register changes and the output is 0. Raising enable again resumes the exact sequence that was interrupted.
- R7: Over one full period of P cycles, the sum of the outputs equals frac·P/(2^N−1).
- R8: For N=5, the sequence period is at least (2^N−1)^2 both for a zero input and for a power-of-two input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Reference-rate clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| en_i | input | 1 | Advance enable; low freezes state and zeroes the output |
| frac_i | input | ACC_W | Unsigned fractional word |
| ofs_o | output | 4 | Signed divide-ratio offset |

## Verification
The assertions assume that the fractional word and enable are steady around each rising edge, and that the fractional word is an unsigned value below 2^N. The modular step check also assumes that reset is released only between edges. The stimulus changes inputs only on falling edges, uses values from 0 up to 2^N−1, and toggles reset only on falling edges. The bench uses a 5-bit accumulator, so that whole periods (up to about 30k cycles) fit within the run. It checks each output cycle against a model built from R1 to R4.

// File: rtl/mash_pkg.sv
package mash_pkg;
  localparam int NUM_STAGES = 3;
  localparam int OFS_W      = 4;
  localparam int OFS_MIN    = -3;
  localparam int OFS_MAX    = 4;
  typedef logic signed [OFS_W-1:0] ofs_t;
endpackage

// File: rtl/mash_acc_stage.sv
module mash_acc_stage #(
  parameter int unsigned W    = 16,
  parameter logic        SEED = 1'b0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         en_i,
  input  logic [W-1:0] add_i,
  output logic [W-1:0] acc_o,
  output logic         carry_o
);
  localparam logic [W+1:0] MODV = (W+2)'((64'd1 << W) - 64'd1);

  logic [W-1:0] acc_q;
  logic         carry_q;
  logic [W:0]   sum;

  // own carry from the previous cycle re-enters the sum (end-around, delayed)
  assign sum = {1'b0, acc_q} + {1'b0, add_i} + {{W{1'b0}}, carry_q};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q   <= {{(W-1){1'b0}}, SEED};
      carry_q <= 1'b0;
    end else if (en_i) begin
      acc_q   <= sum[W-1:0];
      carry_q <= sum[W];
    end
  end

  assign acc_o   = acc_q;
  assign carry_o = carry_q;

  logic [W+1:0] tot;
  assign tot = {2'b00, acc_q} + {{(W+1){1'b0}}, carry_q};

  // stage behaves as a modulo 2^W-1 accumulator (R2)
  p_mod_step_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i |=> (tot % MODV) == (($past(tot) + {2'b00, $past(add_i)}) % MODV));

  // frozen while idle (R6)
  p_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> $stable(acc_q) && $stable(carry_q));
endmodule

// File: rtl/mash_cancel.sv
module mash_cancel
  import mash_pkg::*;
(
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  en_i,
  input  logic [NUM_STAGES-1:0] carry_i,
  output ofs_t                  ofs_o
);
  // delay lines, two taps per stage
  logic [NUM_STAGES-1:0] d1_q, d2_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      d1_q <= '0;
      d2_q <= '0;
    end else if (en_i) begin
      d1_q <= carry_i;
      d2_q <= d1_q;
    end
  end

  logic signed [4:0] t1, t2, t3, raw;
  assign t1  = $signed({4'b0000, d2_q[0]});
  assign t2  = $signed({4'b0000, d1_q[1]}) - $signed({4'b0000, d2_q[1]});
  assign t3  = $signed({4'b0000, carry_i[2]}) - $signed({3'b000, d1_q[2], 1'b0})
             + $signed({4'b0000, d2_q[2]});
  assign raw = t1 + t2 + t3;

  assign ofs_o = en_i ? raw[OFS_W-1:0] : '0;

  p_range_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (int'(ofs_o) >= OFS_MIN) && (int'(ofs_o) <= OFS_MAX));
endmodule

// File: rtl/mash_dsm.sv
module mash_dsm
  import mash_pkg::*;
#(
  parameter int unsigned ACC_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic [ACC_W-1:0] frac_i,
  output logic [3:0]       ofs_o
);
  logic [ACC_W-1:0]      acc   [NUM_STAGES];
  logic [NUM_STAGES-1:0] carry;
  ofs_t                  ofs;

  for (genvar k = 0; k < NUM_STAGES; k++) begin : g_stage
    logic [ACC_W-1:0] add;
    if (k == 0) begin : g_first
      assign add = frac_i;
    end else begin : g_next
      assign add = acc[k-1];
    end
    mash_acc_stage #(
      .W   (ACC_W),
      .SEED(k == 0)
    ) u_stage (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .en_i   (en_i),
      .add_i  (add),
      .acc_o  (acc[k]),
      .carry_o(carry[k])
    );
  end

  mash_cancel u_cancel (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (en_i),
    .carry_i(carry),
    .ofs_o  (ofs)
  );

  assign ofs_o = ofs;

  p_idle_zero_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |-> ofs_o == 4'd0);
endmodule

// File: tb/mash_dsm_tb.sv
module mash_dsm_tb;
  localparam int BN   = 5;
  localparam int MODN = (1 << BN) - 1;
  localparam int CAP  = 60000;

  typedef struct packed {
    logic [BN-1:0] a1, a2, a3;
    logic c1, c2, c3;
    logic c1d1, c1d2, c2d1, c2d2, c3d1, c3d2;
  } st_t;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          en_i = 1'b0;
  logic [BN-1:0] frac_i = '0;
  logic [3:0]    ofs_o;

  int checks = 0, fails = 0;
  int expq[$];
  int last_obs;
  bit done = 0;
  st_t ms;

  mash_dsm #(.ACC_W(BN)) u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .en_i(en_i), .frac_i(frac_i), .ofs_o(ofs_o)
  );

  always #10 clk_i = ~clk_i;

  function automatic st_t st_reset();
    st_t s = '0;
    s.a1 = BN'(1);
    return s;
  endfunction

  function automatic st_t st_step(st_t s, logic [BN-1:0] x);
    st_t n = s;
    logic [BN:0] t;
    t = {1'b0, s.a1} + {1'b0, x}    + {{BN{1'b0}}, s.c1}; n.a1 = t[BN-1:0]; n.c1 = t[BN];
    t = {1'b0, s.a2} + {1'b0, s.a1} + {{BN{1'b0}}, s.c2}; n.a2 = t[BN-1:0]; n.c2 = t[BN];
    t = {1'b0, s.a3} + {1'b0, s.a2} + {{BN{1'b0}}, s.c3}; n.a3 = t[BN-1:0]; n.c3 = t[BN];
    n.c1d1 = s.c1; n.c1d2 = s.c1d1;
    n.c2d1 = s.c2; n.c2d2 = s.c2d1;
    n.c3d1 = s.c3; n.c3d2 = s.c3d1;
    return n;
  endfunction

  function automatic int st_out(st_t s);
    return int'(s.c1d2) + int'(s.c2d1) - int'(s.c2d2)
         + int'(s.c3) - 2 * int'(s.c3d1) + int'(s.c3d2);
  endfunction

  task automatic check(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // driver: one cycle of stimulus, expected value goes to the scoreboard
  task automatic drive(bit en, logic [BN-1:0] x);
    @(negedge clk_i);
    en_i = en;
    frac_i = x;
    expq.push_back(en ? st_out(ms) : 0);
    #3 last_obs = int'($signed(ofs_o));
    if (en) ms = st_step(ms, x);
  endtask

  // monitor
  always @(negedge clk_i) begin
    #2;
    if (expq.size() > 0) begin
      int e, a;
      e = expq.pop_front();
      a = int'($signed(ofs_o));
      check(a == e, "R2 R3 R4 R6 sequence", a, e);
      check(a >= -3 && a <= 4, "R5 range", a, -3);
    end
  end

  task automatic do_reset();
    @(negedge clk_i);
    rst_ni = 1'b0;
    en_i = 1'b0;
    @(negedge clk_i);
    rst_ni = 1'b1;
    ms = st_reset();
    #3 check(int'($signed(ofs_o)) == 0, "R1 reset output", int'($signed(ofs_o)), 0);
  endtask

  task automatic period_test(logic [BN-1:0] x, string tag);
    int p, sum;
    st_t s0, s;
    for (int i = 0; i < 100; i++) drive(1'b1, x);
    s0 = ms;
    s = st_step(s0, x);
    p = 1;
    while (s != s0 && p < CAP) begin
      s = st_step(s, x);
      p++;
    end
    check(p >= MODN * MODN && p < CAP, {"R8 period ", tag}, p, MODN * MODN);
    sum = 0;
    for (int i = 0; i < p; i++) begin
      drive(1'b1, x);
      sum += last_obs;
    end
    check(sum * MODN == int'(x) * p, {"R7 mean ", tag}, sum * MODN, int'(x) * p);
  endtask

  initial begin
    ms = st_reset();
    #25 rst_ni = 1'b1;
    @(negedge clk_i);
    #3 check(int'($signed(ofs_o)) == 0, "R1 idle after reset", int'($signed(ofs_o)), 0);
    // first enabled output after reset is 0 (R1)
    drive(1'b1, BN'(0));
    check(last_obs == 0, "R1 first output", last_obs, 0);

    do_reset();
    period_test(BN'(0), "zero");
    do_reset();
    period_test(BN'(8), "pow2");

    // enable gap: state freezes, output zero, sequence resumes (R6)
    do_reset();
    for (int i = 0; i < 200; i++) drive(1'b1, BN'(21));
    for (int i = 0; i < 20; i++) begin
      drive(1'b0, BN'(21));
      check(last_obs == 0, "R6 idle output", last_obs, 0);
    end
    for (int i = 0; i < 200; i++) drive(1'b1, BN'(21));

    // full-scale input and mid-run reset (R1)
    for (int i = 0; i < 300; i++) drive(1'b1, BN'(31));
    do_reset();
    for (int i = 0; i < 300; i++) drive(1'b1, BN'(13));
    for (int i = 0; i < 300; i++) drive(1'b1, BN'(1));

    repeat (3) @(negedge clk_i);
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    end
    $finish;
  end

  initial begin
    #(20 * 200000);
    if (!done) begin
      done = 1;
      fails++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    end
    $finish;
  end
endmodule